// File: doc/BRIEF.md
# Command-Driven Byte Store Reader

This block is the front end of a byte-wide read-only store that a host controller reaches through a few wires instead of a full address bus. The controller uses an 8-bit data bus, an active-low chip select, an active-low write strobe, an active-low read strobe and a 3-bit register select. It loads a 19-bit start address in one to three byte writes, then pulses the read strobe to fetch consecutive bytes. After each fetch the address moves forward by one.

An internal byte slot pointer decides which part of the address the next write fills. The pointer goes back to the lowest byte when the block is deselected or when the store is read. Traffic addressed to the expansion port registers, which are selected by a set top select bit, leaves the pointer alone. A host interrupted in the middle of an address load can therefore service those ports and then finish the load. All strobes are synchronized into one system clock and edge-detected there. The stored contents come from a lookup table built at elaboration.

Top module: `cmdrom_reader`

## Requirements
- R1: After reset the bus is not driven (`bus_oe` = 0), the address is 0 and the slot pointer selects the lowest byte.
- R2: With `reg_sel[2]` = 0, successive writes after a pointer restart load address bits 7..0, then 15..8, then 18..16. Bits 18..16 take `bus_in[2:0]`. Each byte is taken from `bus_in` when the write strobe rises.
- R3: While `reg_sel[2]` = 0, the values of `reg_sel[1:0]` have no effect on writes or reads.
- R4: Once the pointer reaches the top byte, every further write reloads bits 18..16 until the pointer restarts.
- R5: A reload of only the low byte, or of the low and middle bytes, keeps all higher address bits unchanged.
- R6: While `cs_n` is high the pointer is held at the lowest byte.
- R7: While `rd_n` is low with `reg_sel[2]` = 0, the pointer is held at the lowest byte.
- R8: Writes and reads with `reg_sel[2]` = 1 neither move nor restart the pointer, do not change the address, and never drive the bus.
- R9: `bus_oe` is 1 only while `cs_n` = 0, `rd_n` = 0 and `reg_sel[2]` = 0. While it is 1, `bus_out` carries the byte at the current address.
- R10: Each rising edge of `rd_n` in a store read adds one to the address. The address wraps from 0x7FFFF to 0.
- R11: While `cs_n` is high, write and read strobes change neither the address nor the bus.
- R12: The byte at address A is T(A[7:0]) XOR A[15:8] XOR (A[18:16] shifted left by 5), where T(i) = (37*i + 11) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| reg_sel | input | 3 | Register select; bit 2 = 0 addresses the store |
| bus_in | input | 8 | Data bus input side |
| bus_out | output | 8 | Data bus output side |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
The bench goes after three things. The first is pointer bookkeeping. An address load is broken up by port-register traffic, by a deselect and by a store read. A pointer that advanced on port writes would put the resumed byte in the wrong slot. A pointer that failed to restart would load the middle byte where the low byte belongs. The second is the address boundaries. A partial reload must keep the upper bits, and a slip there shows up as the wrong page in the fetched data. The counter must also wrap from the last address to zero, and a counter wider or narrower than 19 bits returns a wrong byte after 0x7FFFF. The third is an isolation case: strobes while deselected and reads of port registers must leave both the address and the bus untouched. A sweep of all 256 low-byte reloads and a 40-byte run that crosses a page boundary check the table contents and the increment carry.

// File: rtl/cmdrom_pkg.sv
package cmdrom_pkg;

    localparam int BYTE_W = 8;
    localparam int LOW_HI = 7;
    localparam int MID_LO = 8;
    localparam int MID_HI = 15;
    localparam int TOP_LO = 16;

    typedef enum logic [1:0] {
        SLOT_LOW = 2'd0,
        SLOT_MID = 2'd1,
        SLOT_TOP = 2'd2
    } slot_e;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } strobe_t;

    // Slot pointer advance: saturates on the top byte
    function automatic slot_e slot_next(input slot_e s);
        case (s)
            SLOT_LOW: return SLOT_MID;
            SLOT_MID: return SLOT_TOP;
            default:  return SLOT_TOP;
        endcase
    endfunction

    // Table contents generator
    function automatic logic [BYTE_W-1:0] table_entry(input int unsigned i);
        int unsigned v;
        v = (i * 32'd37 + 32'd11) % 32'd256;
        return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import cmdrom_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    raw,
    output strobe_t st
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], raw};
            prev  <= chain[TOP];
        end
    end

    always_comb begin
        st.level = chain[TOP];
        st.fall  = prev & ~chain[TOP];
        st.rise  = ~prev & chain[TOP];
    end
endmodule

// File: rtl/addr_loader.sv
module addr_loader
    import cmdrom_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           cs_st,
    input  strobe_t           wr_st,
    input  strobe_t           rd_st,
    input  logic              mem_sel,
    input  logic [BYTE_W-1:0] din,
    output logic [ADDR_W-1:0] addr,
    output slot_e             slot
);
    localparam int TOP_W = ADDR_W - TOP_LO;

    slot_e tgt;
    logic  armed;
    logic  hold;
    logic  active;

    assign active = ~cs_st.level;
    assign hold   = cs_st.level | (~rd_st.level & mem_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot  <= SLOT_LOW;
            tgt   <= SLOT_LOW;
            armed <= 1'b0;
            addr  <= '0;
        end else begin
            if (hold) begin
                slot <= SLOT_LOW;
            end else if (wr_st.fall && mem_sel) begin
                tgt   <= slot;
                slot  <= slot_next(slot);
                armed <= 1'b1;
            end

            if (active && wr_st.rise && armed) begin
                armed <= 1'b0;
                case (tgt)
                    SLOT_LOW: addr[LOW_HI:0]      <= din;
                    SLOT_MID: addr[MID_HI:MID_LO] <= din;
                    default:  addr[ADDR_W-1:TOP_LO] <= din[TOP_W-1:0];
                endcase
            end else if (active && mem_sel && rd_st.rise) begin
                addr <= addr + 1'b1;
            end

            if (cs_st.level) begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rom_table.sv
module rom_table
    import cmdrom_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int TBL_AW = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] data
);
    localparam int DEPTH = 1 << TBL_AW;
    localparam int TOP_W = ADDR_W - TOP_LO;

    logic [BYTE_W-1:0] tbl [DEPTH];
    logic [BYTE_W-1:0] bank;

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        assign tbl[g] = table_entry(g);
    end

    assign bank = BYTE_W'(addr[ADDR_W-1:TOP_LO]) << (BYTE_W - TOP_W);
    assign data = tbl[addr[TBL_AW-1:0]] ^ addr[MID_HI:MID_LO] ^ bank;
endmodule

// File: rtl/bus_drive.sv
module bus_drive
    import cmdrom_pkg::*;
(
    input  logic              cs_lvl,
    input  logic              rd_lvl,
    input  logic              mem_sel,
    input  logic [BYTE_W-1:0] data,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe
);
    assign bus_oe  = ~cs_lvl & ~rd_lvl & mem_sel;
    assign bus_out = bus_oe ? data : '0;
endmodule

// File: rtl/cmdrom_reader.sv
module cmdrom_reader
    import cmdrom_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int TBL_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_oe
);
    localparam int N_STROBE = 3;
    localparam int IDX_CS   = 0;
    localparam int IDX_WR   = 1;
    localparam int IDX_RD   = 2;

    logic [N_STROBE-1:0] raw;
    strobe_t             st [N_STROBE];
    logic                mem_sel;
    logic [ADDR_W-1:0]   addr_q;
    slot_e               slot_q;
    logic [BYTE_W-1:0]   rom_data;

    assign raw     = {rd_n, wr_n, cs_n};
    assign mem_sel = ~reg_sel[2];

    for (genvar g = 0; g < N_STROBE; g++) begin : g_sync
        strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .raw (raw[g]),
            .st  (st[g])
        );
    end

    addr_loader #(.ADDR_W(ADDR_W)) u_loader (
        .clk     (clk),
        .rst     (rst),
        .cs_st   (st[IDX_CS]),
        .wr_st   (st[IDX_WR]),
        .rd_st   (st[IDX_RD]),
        .mem_sel (mem_sel),
        .din     (bus_in),
        .addr    (addr_q),
        .slot    (slot_q)
    );

    rom_table #(.ADDR_W(ADDR_W), .TBL_AW(TBL_AW)) u_rom (
        .addr (addr_q),
        .data (rom_data)
    );

    bus_drive u_bus (
        .cs_lvl  (st[IDX_CS].level),
        .rd_lvl  (st[IDX_RD].level),
        .mem_sel (mem_sel),
        .data    (rom_data),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );
endmodule

// File: rtl/cmdrom_reader_chk.sv
module cmdrom_reader_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              bus_oe,
    input logic              cs_lvl,
    input logic              rd_lvl,
    input logic              wr_fall,
    input logic              wr_rise,
    input logic              rd_rise,
    input logic              mem_sel,
    input logic [1:0]        slot,
    input logic [ADDR_W-1:0] addr
);
    // R6
    slot_clear_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        cs_lvl |=> (slot == 2'd0));

    // R7
    slot_clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_lvl && mem_sel) |=> (slot == 2'd0));

    // R8
    port_write_keeps_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_fall && !mem_sel && !cs_lvl) |=> $stable(slot));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && mem_sel && !cs_lvl && !wr_rise) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

    // R11
    deselect_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        cs_lvl |=> $stable(addr));

    // R9
    drive_needs_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!$past(cs_n, 2) && !$past(rd_n, 2)));
endmodule

bind cmdrom_reader cmdrom_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .bus_oe  (bus_oe),
    .cs_lvl  (st[0].level),
    .rd_lvl  (st[2].level),
    .wr_fall (st[1].fall),
    .wr_rise (st[1].rise),
    .rd_rise (st[2].rise),
    .mem_sel (mem_sel),
    .slot    (slot_q),
    .addr    (addr_q)
);

// File: tb/sim_cmdrom_reader.sv
module sim_cmdrom_reader;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [2:0] reg_sel = 3'b000;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic [18:0] ma = '0;

    always #(CLK_P/2) clk = ~clk;

    cmdrom_reader u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .reg_sel(reg_sel), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    function automatic logic [7:0] expb(input logic [18:0] a);
        int unsigned t;
        t = (32'(a[7:0]) * 32'd37 + 32'd11) % 32'd256;
        return t[7:0] ^ a[15:8] ^ {a[18:16], 5'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [2:0] sel, input logic [7:0] d);
        reg_sel = sel; bus_in = d; waitc(2);
        wr_n = 1'b0; waitc(4);
        wr_n = 1'b1; waitc(4);
    endtask

    task automatic rd_pulse(input logic [2:0] sel, output logic [7:0] d, output logic oe);
        reg_sel = sel; waitc(2);
        rd_n = 1'b0; waitc(4);
        d = bus_out; oe = bus_oe;
        rd_n = 1'b1; waitc(4);
    endtask

    task automatic rd_mem(input string tag, input logic [2:0] sel);
        logic [7:0] d; logic oe;
        rd_pulse(sel, d, oe);
        chk({tag, " oe"}, 32'(oe), 32'd1);
        chk({tag, " data"}, 32'(d), 32'(expb(ma)));
        ma = ma + 1'b1;
    endtask

    task automatic set_cs(input logic v);
        cs_n = v; waitc(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d; logic oe;
        waitc(6);
        rst = 1'b0;
        waitc(2);
        // R1: idle after reset
        chk("R1 oe after reset", 32'(bus_oe), 32'd0);
        set_cs(1'b0);
        chk("R1 oe selected idle", 32'(bus_oe), 32'd0);
        rd_mem("R1 first read at address 0", 3'b000);

        // R2 / R3: three-byte load with varied low select bits
        wr_byte(3'b000, 8'h34);
        wr_byte(3'b001, 8'h12);
        wr_byte(3'b011, 8'hFD);
        ma = 19'h51234;
        for (int i = 0; i < 4; i++) rd_mem("R2 R3 full load", 3'(i));

        // R12 / R10: run across a page boundary
        wr_byte(3'b010, 8'hF0);
        wr_byte(3'b000, 8'h0A);
        wr_byte(3'b000, 8'h02);
        ma = 19'h20AF0;
        for (int i = 0; i < 40; i++) rd_mem("R12 R10 page crossing run", 3'b000);

        // R5 / R12: sweep of every low-byte reload
        for (int k = 0; k < 256; k++) begin
            wr_byte(3'b000, 8'(k));
            ma = {ma[18:8], 8'(k)};
            rd_mem("R5 R12 low-byte sweep", 3'b000);
        end

        // R5: two-byte reload keeps the top bits
        wr_byte(3'b000, 8'h11);
        wr_byte(3'b000, 8'h22);
        ma = {ma[18:16], 16'h2211};
        rd_mem("R5 two-byte reload", 3'b000);

        // R4: fourth write reloads the top byte
        wr_byte(3'b000, 8'h01);
        wr_byte(3'b000, 8'h02);
        wr_byte(3'b000, 8'h03);
        wr_byte(3'b000, 8'h06);
        ma = 19'h60201;
        rd_mem("R4 repeated top write", 3'b000);

        // R6: deselect restarts the pointer
        wr_byte(3'b000, 8'h44);
        set_cs(1'b1);
        set_cs(1'b0);
        wr_byte(3'b000, 8'h55);
        ma = {ma[18:8], 8'h55};
        rd_mem("R6 restart on deselect", 3'b000);

        // R8: port traffic in the middle of a load
        wr_byte(3'b000, 8'h77);
        wr_byte(3'b100, 8'hAA);
        rd_pulse(3'b110, d, oe);
        chk("R8 port read not driven", 32'(oe), 32'd0);
        wr_byte(3'b101, 8'h5A);
        wr_byte(3'b000, 8'h66);
        ma = {ma[18:16], 16'h6677};
        rd_mem("R8 resumed load", 3'b000);

        // R7: store read restarts the pointer
        wr_byte(3'b000, 8'h10);
        ma = {ma[18:8], 8'h10};
        rd_mem("R7 read after one byte", 3'b000);
        wr_byte(3'b000, 8'h20);
        ma = {ma[18:8], 8'h20};
        rd_mem("R7 restart on read", 3'b000);

        // R11: strobes while deselected
        set_cs(1'b1);
        wr_byte(3'b000, 8'h99);
        rd_pulse(3'b000, d, oe);
        chk("R11 R9 deselected read not driven", 32'(oe), 32'd0);
        set_cs(1'b0);
        rd_mem("R11 address unchanged", 3'b000);

        // R10: wrap at the last address
        wr_byte(3'b000, 8'hFF);
        wr_byte(3'b000, 8'hFF);
        wr_byte(3'b000, 8'h07);
        ma = 19'h7FFFF;
        rd_mem("R10 last address", 3'b000);
        rd_mem("R10 wrapped to zero", 3'b000);
        chk("R9 idle after read", 32'(bus_oe), 32'd0);

        finish_run();
    end
endmodule